// File: doc/BRIEF.md
# Stop-State Wake Recovery Sequencer

This block brings a device out of its low-power stop state. Several groups of wake lines, each line with its own enable bit, are merged into a single wake event. The event is only accepted while the stop-state flag is high. Once an event is accepted, the block takes one of two paths. With the delay bit set, it waits out a fixed clock-stabilisation interval. With the delay bit clear, it skips that interval but requires the merged source to stay active for a minimum run of consecutive input clocks.

When the chosen path completes, the block issues a single-cycle resume strobe. At the same edge it raises a recovery flag. This flag models the control bit that a recovery sets rather than clears.

The block can also route the wake event to an interrupt line, with an active-low cause pin marking that a wake is under way. A configuration-error output flags the unsafe case of a crystal or resonator clock selected with the delay skipped. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `stop_wake_seq`

## Requirements
- R1: The merged wake event is the OR, over all NGRP groups of GRP_W lines, of each line of `wake_src` ANDed with the same bit of `wake_en`; a line whose enable bit is 0 never causes a wake.
- R2: While `stop_mode` is 0, no wake is accepted: `resume` stays 0 and `irq_wake` stays 0 whatever the sources do.
- R3: With `dly_en`=1, a wake accepted at clock edge k drives `resume` high in the cycle after edge k+DLY_N, even if the source goes away after edge k.
- R4: With `dly_en`=0, the merged event must be sampled high on QUAL_N consecutive edges; `resume` is high in the cycle after the QUAL_N-th such edge.
- R5: With `dly_en`=0, if the merged event is sampled low before QUAL_N consecutive samples, the qualification restarts from zero.
- R6: `resume` is a pulse exactly one clock cycle wide.
- R7: `recov_flag` is 0 after reset and becomes 1 in the same cycle as `resume`. It stays 1 until the block is idle with `stop_mode` high, and is then cleared on the next edge.
- R8: `cfg_err` is 1 exactly when `xtal_sel`=1 and `dly_en`=0.
- R9: With `route_en`=1, `irq_wake` is 1 and `wake_cause_n` is 0 from the edge that accepts a wake through the `resume` cycle. With `route_en`=0, `irq_wake` is 0 and `wake_cause_n` is 1.
- R10: After a resume, no further wake is accepted until `stop_mode` has been seen at 0 and then raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_mode | input | 1 | High while the device sits in the stop state |
| wake_src | input | NGRP*GRP_W | Wake source lines, group g at bits g*GRP_W upward |
| wake_en | input | NGRP*GRP_W | Per-line enable for the wake sources |
| dly_en | input | 1 | 1: run the stabilisation delay; 0: skip it and qualify the source |
| xtal_sel | input | 1 | Clock source is a crystal or resonator |
| route_en | input | 1 | Route wake events to the interrupt line and cause pin |
| resume | output | 1 | One-cycle strobe: execution may restart |
| recov_flag | output | 1 | Set by a recovery |
| cfg_err | output | 1 | Delay skipped with a crystal clock selected |
| irq_wake | output | 1 | Wake interrupt request (level) |
| wake_cause_n | output | 1 | Active-low wake-in-progress pin |

## Verification
A sequencer stuck in the wrong state shows up at `irq_wake` one edge after the source changes. `irq_wake` either fails to rise on an accepted wake or stays high after the wake ends. A counter that is off by one moves the `resume` pulse by one cycle, so the bench counts edges from acceptance and checks the exact cycle in which `resume` appears. A missed restart of the qualifier, or a missed return to idle, produces an early or an extra resume within a few dozen cycles.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_QUAL  = 3'd1,
    ST_DELAY = 3'd2,
    ST_DONE  = 3'd3,
    ST_RUN   = 3'd4
  } wake_st_e;
endpackage

// File: rtl/wake_merge.sv
module wake_merge #(
  parameter int NGRP  = 4,
  parameter int GRP_W = 4
) (
  input  logic                  stop_mode,
  input  logic [NGRP*GRP_W-1:0] wake_src,
  input  logic [NGRP*GRP_W-1:0] wake_en,
  output logic                  wake
);
  logic [NGRP-1:0] grp_hit;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_hit[g] = |(wake_src[g*GRP_W +: GRP_W] & wake_en[g*GRP_W +: GRP_W]);
  end

  assign wake = stop_mode & (|grp_hit);
endmodule

// File: rtl/wake_tick_cnt.sv
module wake_tick_cnt #(
  parameter int LIMIT = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [W-1:0] cnt;

  assign hit = run && (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (hit)    cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= W'(LIMIT - 1)); // R3
  AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0); // R5
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
  import wake_pkg::*;
#(
  parameter int NGRP   = 4,
  parameter int GRP_W  = 4,
  parameter int QUAL_N = 10,
  parameter int DLY_N  = 1024
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stop_mode,
  input  logic [NGRP*GRP_W-1:0] wake_src,
  input  logic [NGRP*GRP_W-1:0] wake_en,
  input  logic                  dly_en,
  input  logic                  xtal_sel,
  input  logic                  route_en,
  output logic                  resume,
  output logic                  recov_flag,
  output logic                  cfg_err,
  output logic                  irq_wake,
  output logic                  wake_cause_n
);
  localparam int QUAL_LIM = QUAL_N - 1;

  wake_st_e st, st_nx;
  logic     wake;
  logic     qual_hit, dly_hit;
  logic     busy;

  wake_merge #(.NGRP(NGRP), .GRP_W(GRP_W)) u_merge (
    .stop_mode (stop_mode),
    .wake_src  (wake_src),
    .wake_en   (wake_en),
    .wake      (wake)
  );

  wake_tick_cnt #(.LIMIT(QUAL_LIM)) u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .run   ((st == ST_QUAL) && wake),
    .hit   (qual_hit)
  );

  wake_tick_cnt #(.LIMIT(DLY_N)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (st == ST_DELAY),
    .hit   (dly_hit)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (wake) st_nx = dly_en ? ST_DELAY : ST_QUAL;
      ST_QUAL:  if (!wake) st_nx = ST_IDLE;
                else if (qual_hit) st_nx = ST_DONE;
      ST_DELAY: if (dly_hit) st_nx = ST_DONE;
      ST_DONE:  st_nx = ST_RUN;
      ST_RUN:   if (!stop_mode) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      recov_flag <= 1'b0;
    end else begin
      st <= st_nx;
      if (st_nx == ST_DONE)
        recov_flag <= 1'b1;
      else if (st == ST_IDLE && stop_mode)
        recov_flag <= 1'b0;
    end
  end

  assign busy         = (st == ST_QUAL) || (st == ST_DELAY) || (st == ST_DONE);
  assign resume       = (st == ST_DONE);
  assign cfg_err      = xtal_sel & ~dly_en;
  assign irq_wake     = route_en & busy;
  assign wake_cause_n = ~(route_en & busy);

  AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume); // R6
  AST_FLAG_WITH_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> recov_flag); // R7
  AST_NO_WAKE_OUTSIDE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !stop_mode) |=> st == ST_IDLE); // R2
  AST_QUAL_DROP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_QUAL && !wake) |=> st == ST_IDLE); // R5
  AST_RUN_HOLDS_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && stop_mode) |=> !resume && !busy); // R10
  AST_DONE_FROM_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> ($past(st) == ST_QUAL || $past(st) == ST_DELAY)); // R4
endmodule

// File: tb/sim_stop_wake_seq.sv
module sim_stop_wake_seq;
  localparam int NGRP = 4, GRP_W = 4, QUAL_N = 10, DLY_N = 16;
  localparam int NV = 8;
  // {wake_src, wake_en, expected irq_wake one edge later}
  localparam logic [32:0] VEC [NV] = '{
    {16'h0001, 16'h0001, 1'b1},
    {16'h0001, 16'h0000, 1'b0},
    {16'h8000, 16'h8000, 1'b1},
    {16'h00F0, 16'h0F00, 1'b0},
    {16'h0F00, 16'h0100, 1'b1},
    {16'hFFFF, 16'h0000, 1'b0},
    {16'h0000, 16'hFFFF, 1'b0},
    {16'h0020, 16'h0030, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic stop_mode = 1'b0, dly_en = 1'b0, xtal_sel = 1'b0, route_en = 1'b1;
  logic [15:0] wake_src = '0, wake_en = '0;
  logic resume, recov_flag, cfg_err, irq_wake, wake_cause_n;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  stop_wake_seq #(.NGRP(NGRP), .GRP_W(GRP_W), .QUAL_N(QUAL_N), .DLY_N(DLY_N)) u0 (
    .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .wake_src(wake_src),
    .wake_en(wake_en), .dly_en(dly_en), .xtal_sel(xtal_sel), .route_en(route_en),
    .resume(resume), .recov_flag(recov_flag), .cfg_err(cfg_err),
    .irq_wake(irq_wake), .wake_cause_n(wake_cause_n)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edge_s();
    @(posedge clk); #1;
  endtask

  task automatic leave_stop();
    @(negedge clk); stop_mode = 1'b0; wake_src = '0;
    edge_s(); edge_s();
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #12;
    chk("R7 reset flag", recov_flag, 0);
    chk("R6 reset resume", resume, 0);
    chk("R9 reset pin", wake_cause_n, 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); stop_mode = 1'b1;

    // R1 table: merge of enabled lines, seen through irq_wake
    for (int v = 0; v < NV; v++) begin
      @(negedge clk); wake_src = VEC[v][32:17]; wake_en = VEC[v][16:1];
      edge_s();
      chk($sformatf("R1 vec%0d irq", v), irq_wake, VEC[v][0]);
      chk($sformatf("R9 vec%0d pin", v), wake_cause_n, !VEC[v][0]);
      @(negedge clk); wake_src = '0;
      edge_s();
    end

    // R2: sources active with stop_mode low
    @(negedge clk); stop_mode = 1'b0; wake_en = 16'h0001; wake_src = 16'h0001;
    for (int i = 0; i < 30; i++) begin
      edge_s();
      if (resume || irq_wake) chk("R2 wake outside stop", {resume, irq_wake}, 0);
    end
    chk("R2 no resume", resume, 0);

    // R4/R6/R7/R9: qualified path, source held
    @(negedge clk); stop_mode = 1'b1; dly_en = 1'b0;
    for (int i = 1; i <= 12; i++) begin
      edge_s();
      chk($sformatf("R4 qual edge %0d resume", i), resume, (i == QUAL_N));
      if (i == QUAL_N) chk("R7 flag with resume", recov_flag, 1);
      if (i == QUAL_N + 1) chk("R9 irq after resume", irq_wake, 0);
      if (i == 1) chk("R9 irq during wake", irq_wake, 1);
    end
    // R10: still in stop, source active: no further resume
    for (int i = 0; i < 30; i++) begin
      edge_s();
      if (resume) chk("R10 extra resume", resume, 0);
    end
    chk("R7 flag held", recov_flag, 1);
    leave_stop();
    @(negedge clk); stop_mode = 1'b1;
    edge_s(); edge_s();
    chk("R7 flag cleared on new stop", recov_flag, 0);

    // R5: drop after 5 samples, then hold
    @(negedge clk); wake_src = 16'h0001;
    for (int i = 0; i < 5; i++) edge_s();
    @(negedge clk); wake_src = '0;
    edge_s();
    chk("R5 no resume after drop", resume, 0);
    @(negedge clk); wake_src = 16'h0001;
    for (int i = 1; i <= 11; i++) begin
      edge_s();
      chk($sformatf("R5 restart edge %0d", i), resume, (i == QUAL_N));
    end
    leave_stop();

    // R3: delay path, one-cycle source pulse, route disabled
    @(negedge clk); stop_mode = 1'b1; dly_en = 1'b1; route_en = 1'b0;
    edge_s(); edge_s();
    @(negedge clk); wake_src = 16'h0001;
    edge_s();
    chk("R9 unrouted irq", irq_wake, 0);
    chk("R9 unrouted pin", wake_cause_n, 1);
    @(negedge clk); wake_src = '0;
    for (int i = 2; i <= DLY_N + 3; i++) begin
      edge_s();
      chk($sformatf("R3 delay edge %0d", i), resume, (i == DLY_N + 1));
    end
    leave_stop();
    route_en = 1'b1;

    // R8: configuration error
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); xtal_sel = c[1]; dly_en = c[0];
      #1 chk($sformatf("R8 combo %0d", c), cfg_err, (c == 2));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule